// File: doc/BRIEF.md
# Vector Find Element Equal or Unequal

This unit scans two 128-bit operands, A and B, one element position at a time. The element size is 8, 16 or 32 bits. In equal mode it looks for the first position where the A element and the B element match. In unequal mode it looks for the first position where they differ. An optional zero search also finds the first all-zero element of A.

The unit reports the earlier of the two events as a byte offset. Byte 0 is the most significant byte. It also returns a two-bit condition code. In unequal mode the code also shows which operand holds the smaller unsigned value at the first difference, which lets the unit act as one step of a string compare.

A request is a one-cycle pulse on `start_i`. The unit captures the result into registers. The result appears with `done_o` on the next cycle and holds until the next request.

Top module: `vfe_unit`

## Requirements
- R1: `done_o` is high in the cycle after each cycle in which `start_i` is high, and low otherwise. `result_o` and `cc_o` change only at the clock edge that captures a request.
- R2: Element size is selected by `esize_i`: 0 gives 8-bit elements, 1 gives 16-bit elements, and 2 or 3 give 32-bit elements. Elements are compared only as whole units.
- R3: Byte 0 is bits 127:120 of an operand. Element k of an s-byte size starts at byte k*s, and an event in that element is reported as offset k*s.
- R4: With `mode_i`=0 (equal mode), a position is flagged when the A element and the B element are identical. `result_o[127:64]` is the smaller of the first flagged offset and the first zero offset, or 16 when neither exists.
- R5: With `mode_i`=1 (unequal mode), a position is flagged when the A element and the B element differ. The same offset rule as R4 applies.
- R6: `result_o[63:0]` is always zero after a request.
- R7: When `zs_en_i`=1, the first element of A that is all zeros is located. When `zs_en_i`=0, the zero position is taken as 16, so zero elements do not affect the result.
- R8: In equal mode, `cc_o` is:
  - 3 when there is no equal pair and no zero;
  - 1 when there is an equal pair but no zero;
  - 2 when the first equal pair is strictly before the zero;
  - 0 otherwise.
- R9: In unequal mode, `cc_o` is:
  - 3 when there is no difference and no zero;
  - 0 when the zero is strictly before the first difference.
- R10: In all other unequal-mode cases, `cc_o` is 1 when A's element at the first difference is unsigned less than B's element there, and 2 otherwise. This rule also applies when the zero and the difference are at the same position.
- R11: After reset, `done_o`, `result_o` and `cc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| a_i | input | 128 | Operand A |
| b_i | input | 128 | Operand B |
| esize_i | input | 2 | Element size code |
| mode_i | input | 1 | 0 = find equal, 1 = find unequal |
| zs_en_i | input | 1 | Enable zero search on A |
| done_o | output | 1 | Result valid, one cycle after start_i |
| result_o | output | 128 | Byte offset in 127:64, zero in 63:0 |
| cc_o | output | 2 | Condition code |

## Verification
All state in the unit sits in the output registers, so a wrong compare or a wrong priority choice shows up as a wrong offset or code in the `done_o` cycle of the same request. Nothing stays hidden in the unit to corrupt later requests. The 16-bit and 32-bit cases include operands that would match at byte granularity but not at the full element size. This catches a wrong size selection. Unequal-mode cases include operand bytes with the top bit set, zeros placed at the same position as the difference, and zeros placed before it. These check the unsigned ordering and the tie rule.

// File: rtl/vfe_pkg.sv
package vfe_pkg;
  localparam int unsigned VEC_W   = 128;
  localparam int unsigned NBYTES  = VEC_W / 8;
  localparam int unsigned IDX_W   = $clog2(NBYTES + 1);
  localparam int unsigned NSIZES  = 3;

  typedef enum logic [1:0] {
    ES_8  = 2'd0,
    ES_16 = 2'd1,
    ES_32 = 2'd2,
    ES_32A = 2'd3
  } esize_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_LO   = 2'd1,
    CC_HI   = 2'd2,
    CC_NONE = 2'd3
  } cc_e;
endpackage

// File: rtl/vfe_elem_cmp.sv
// Per-element compare for one element size; flags land on each element's first byte.
module vfe_elem_cmp #(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned EL_BYTES = 1
) (
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  input  logic               mode_i,
  output logic [VEC_W/8-1:0] hit_o,
  output logic [VEC_W/8-1:0] lt_o,
  output logic [VEC_W/8-1:0] az_o
);
  localparam int unsigned NB   = VEC_W / 8;
  localparam int unsigned EL_W = EL_BYTES * 8;
  localparam int unsigned NEL  = NB / EL_BYTES;

  for (genvar k = 0; k < NEL; k++) begin : g_el
    localparam int unsigned HI  = VEC_W - 1 - k * EL_W;
    localparam int unsigned POS = k * EL_BYTES;
    logic [EL_W-1:0] ea, eb;
    assign ea = a_i[HI -: EL_W];
    assign eb = b_i[HI -: EL_W];
    assign hit_o[POS] = mode_i ? (ea != eb) : (ea == eb);
    assign lt_o[POS]  = ea < eb;
    assign az_o[POS]  = ea == '0;
    for (genvar j = 1; j < EL_BYTES; j++) begin : g_pad
      assign hit_o[POS+j] = 1'b0;
      assign lt_o[POS+j]  = 1'b0;
      assign az_o[POS+j]  = 1'b0;
    end
  end
endmodule

// File: rtl/vfe_first_idx.sv
// Lowest set index of a byte-position vector; N when empty.
module vfe_first_idx #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = IDX_W'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vfe_unit.sv
module vfe_unit
  import vfe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  input  logic [1:0]        esize_i,
  input  logic              mode_i,
  input  logic              zs_en_i,
  output logic              done_o,
  output logic [VEC_W-1:0]  result_o,
  output logic [1:0]        cc_o
);
  localparam logic [IDX_W-1:0] NONE = IDX_W'(NBYTES);

  logic [NBYTES-1:0] hit_s [NSIZES];
  logic [NBYTES-1:0] lt_s  [NSIZES];
  logic [NBYTES-1:0] az_s  [NSIZES];

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    vfe_elem_cmp #(.VEC_W(VEC_W), .EL_BYTES(1 << g)) u_cmp (
      .a_i   (a_i),
      .b_i   (b_i),
      .mode_i(mode_i),
      .hit_o (hit_s[g]),
      .lt_o  (lt_s[g]),
      .az_o  (az_s[g])
    );
  end

  logic [NBYTES-1:0] hit_v, lt_v, az_v;
  always_comb begin
    unique case (esize_i)
      ES_8:    begin hit_v = hit_s[0]; lt_v = lt_s[0]; az_v = az_s[0]; end
      ES_16:   begin hit_v = hit_s[1]; lt_v = lt_s[1]; az_v = az_s[1]; end
      default: begin hit_v = hit_s[2]; lt_v = lt_s[2]; az_v = az_s[2]; end
    endcase
  end

  logic [IDX_W-1:0] first_hit, first_zero;

  vfe_first_idx #(.N(NBYTES), .IDX_W(IDX_W)) u_hit_idx (
    .vec_i(hit_v),
    .idx_o(first_hit)
  );

  vfe_first_idx #(.N(NBYTES), .IDX_W(IDX_W)) u_zero_idx (
    .vec_i(az_v & {NBYTES{zs_en_i}}),
    .idx_o(first_zero)
  );

  logic             a_smaller;
  logic [IDX_W-1:0] idx_min;
  cc_e              cc_d;

  // first_hit < NBYTES guards the narrowed index
  assign a_smaller = (first_hit != NONE) && lt_v[first_hit[IDX_W-2:0]];
  assign idx_min   = (first_hit < first_zero) ? first_hit : first_zero;

  always_comb begin
    if (first_hit == NONE && first_zero == NONE) begin
      cc_d = CC_NONE;
    end else if (!mode_i) begin
      if (first_zero == NONE)          cc_d = CC_LO;
      else if (first_hit < first_zero) cc_d = CC_HI;
      else                             cc_d = CC_ZERO;
    end else begin
      if (first_zero < first_hit) cc_d = CC_ZERO;
      else                        cc_d = a_smaller ? CC_LO : CC_HI;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
      cc_o     <= 2'd0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o <= {{(VEC_W/2-IDX_W){1'b0}}, idx_min, {(VEC_W/2){1'b0}}};
        cc_o     <= cc_d;
      end
    end
  end

  AST_DONE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o) else $error("done missing"); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(cc_o) && !done_o)) else $error("hold"); // R1
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o[VEC_W/2-1:0] == '0) else $error("low half"); // R6
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o[VEC_W-1:VEC_W/2] <= 64'(NBYTES)) else $error("range"); // R4
  AST_CC_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == 2'd3) |-> result_o[VEC_W-1:VEC_W/2] == 64'(NBYTES)) else $error("cc3"); // R8
  AST_CC_ZERO_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == 2'd0) |-> result_o[VEC_W-1:VEC_W/2] < 64'(NBYTES)) else $error("cc0"); // R9
endmodule

// File: tb/sim_vfe_unit.sv
module sim_vfe_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic [1:0]   esize = 2'd0;
  logic         mode = 1'b0;
  logic         zs_en = 1'b0;
  logic         done;
  logic [127:0] result;
  logic [1:0]   cc;

  int n_checks = 0;
  int n_errors = 0;

  logic [127:0] q_res [$];
  logic [1:0]   q_cc  [$];
  string        q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vfe_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .esize_i(esize), .mode_i(mode), .zs_en_i(zs_en),
    .done_o(done), .result_o(result), .cc_o(cc)
  );

  function automatic void ref_model(input logic [127:0] va, vb, input logic [1:0] es,
                                    input logic md, zs,
                                    output logic [127:0] res, output logic [1:0] c);
    int sz, n, fe, fz, idx;
    logic lt;
    logic [31:0] m;
    sz = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;
    n = 16 / sz;
    m = (sz == 4) ? 32'hffff_ffff : ((32'd1 << (sz * 8)) - 32'd1);
    fe = 16; fz = 16; lt = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [127:0] ta, tb;
      logic [31:0] ea, eb;
      ta = va >> ((n - 1 - i) * sz * 8);
      tb = vb >> ((n - 1 - i) * sz * 8);
      ea = ta[31:0] & m;
      eb = tb[31:0] & m;
      if (fe == 16 && (md ? (ea != eb) : (ea == eb))) begin
        fe = i * sz;
        lt = ea < eb;
      end
      if (zs && fz == 16 && ea == 32'd0) fz = i * sz;
    end
    idx = (fe < fz) ? fe : fz;
    res = {64'(idx), 64'd0};
    if (fe == 16 && fz == 16) c = 2'd3;
    else if (!md) c = (fz == 16) ? 2'd1 : (fe < fz) ? 2'd2 : 2'd0;
    else c = (fz < fe) ? 2'd0 : (lt ? 2'd1 : 2'd2);
  endfunction

  task automatic check(input string tag, input logic [127:0] act, exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [127:0] va, vb,
                       input logic [1:0] es, input logic md, zs);
    logic [127:0] er;
    logic [1:0] ec;
    ref_model(va, vb, es, md, zs, er, ec);
    q_res.push_back(er);
    q_cc.push_back(ec);
    q_tag.push_back(tag);
    a = va; b = vb; esize = es; mode = md; zs_en = zs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drive_cc(input string tag, input logic [127:0] va, vb,
                          input logic [1:0] es, input logic md, zs,
                          input int exp_idx, input logic [1:0] exp_cc);
    logic [127:0] er;
    logic [1:0] ec;
    ref_model(va, vb, es, md, zs, er, ec);
    check({tag, " model idx"}, er, {64'(exp_idx), 64'd0});
    check({tag, " model cc"}, 128'(ec), 128'(exp_cc));
    drive(tag, va, vb, es, md, zs);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_res.size() == 0) begin
        check("R1 unexpected done", 128'd1, 128'd0);
      end else begin
        logic [127:0] er;
        logic [1:0] ec;
        string t;
        er = q_res.pop_front();
        ec = q_cc.pop_front();
        t = q_tag.pop_front();
        check({t, " result"}, result, er);
        check({t, " cc"}, 128'(cc), 128'(ec));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  logic [127:0] seq, inv, t1, t2;

  initial begin
    seq = 128'h0102030405060708090a0b0c0d0e0f10;
    inv = ~seq;
    repeat (3) @(negedge clk);
    check("R11 reset done", 128'(done), 128'd0);
    check("R11 reset result", result, 128'd0);
    check("R11 reset cc", 128'(cc), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 equal match at byte 5, no zero search
    t1 = inv; t1[127-5*8 -: 8] = seq[127-5*8 -: 8];
    drive_cc("R4 eq8 byte5", seq, t1, 2'd0, 1'b0, 1'b0, 5, 2'd1);
    // R7 zero at byte 3 beats equal at 5
    t2 = seq; t2[127-3*8 -: 8] = 8'h00;
    drive_cc("R7 zs on", t2, t1, 2'd0, 1'b0, 1'b1, 3, 2'd0);
    // R7 zs off ignores the zero
    drive_cc("R7 zs off", t2, t1, 2'd0, 1'b0, 1'b0, 5, 2'd1);
    // R8 equal before zero
    t1 = inv; t1[127-2*8 -: 8] = seq[127-2*8 -: 8];
    t2 = seq; t2[127-9*8 -: 8] = 8'h00;
    drive_cc("R8 eq before zero", t2, t1, 2'd0, 1'b0, 1'b1, 2, 2'd2);
    // R8 nothing
    drive_cc("R8 none", seq, inv, 2'd0, 1'b0, 1'b1, 16, 2'd3);
    // R2 16-bit: byte 0 equal but halfword 0 differs; halfword 3 equal
    t1 = inv; t1[127 -: 8] = seq[127 -: 8]; t1[127-48 -: 16] = seq[127-48 -: 16];
    drive_cc("R2 R3 eq16", seq, t1, 2'd1, 1'b0, 1'b0, 6, 2'd1);
    drive_cc("R2 eq8 same data", seq, t1, 2'd0, 1'b0, 1'b0, 0, 2'd1);
    // R2 code 3 acts as 32-bit, word 2 equal
    t1 = inv; t1[127-64 -: 32] = seq[127-64 -: 32]; t1[127-16 -: 16] = seq[127-16 -: 16];
    drive_cc("R2 es3 word", seq, t1, 2'd3, 1'b0, 1'b0, 8, 2'd1);
    drive_cc("R2 es2 word", seq, t1, 2'd2, 1'b0, 1'b0, 8, 2'd1);
    // R5 R10 unequal, diff at byte 7, a < b
    t1 = seq; t1[127-56 -: 8] = 8'hf0;
    drive_cc("R5 R10 ne a<b", seq, t1, 2'd0, 1'b1, 1'b0, 7, 2'd1);
    drive_cc("R10 ne a>b", t1, seq, 2'd0, 1'b1, 1'b0, 7, 2'd2);
    // R10 unsigned ordering
    t1 = seq; t1[127 -: 8] = 8'h80;
    t2 = seq; t2[127 -: 8] = 8'h7f;
    drive_cc("R10 unsigned", t1, t2, 2'd0, 1'b1, 1'b0, 0, 2'd2);
    // R9 no diff no zero
    drive_cc("R9 none", seq, seq, 2'd0, 1'b1, 1'b1, 16, 2'd3);
    // R9 zero before diff
    t1 = seq; t1[127-32 -: 8] = 8'h00;
    t2 = t1;  t2[127-80 -: 8] = 8'h55;
    drive_cc("R9 zero first", t1, t2, 2'd0, 1'b1, 1'b1, 4, 2'd0);
    // R10 tie: zero and diff at same byte
    t2 = t1; t2[127-32 -: 8] = 8'h05;
    drive_cc("R10 tie", t1, t2, 2'd0, 1'b1, 1'b1, 4, 2'd1);
    // R3 R5 32-bit difference in low byte of word 2
    t1 = seq; t1[127-88 -: 8] = 8'h00;
    drive_cc("R3 R5 ne32", seq, t1, 2'd2, 1'b1, 1'b0, 8, 2'd2);

    // R1 idle cycle: outputs hold, done low
    @(negedge clk);
    t1 = result;
    a = ~a; b = 128'd0; esize = 2'd1; mode = ~mode; zs_en = 1'b1;
    @(negedge clk);
    check("R1 done low when idle", 128'(done), 128'd0);
    check("R1 result held", result, t1);

    // R4 R5 R6 randomized back-to-back requests
    for (int k = 0; k < 300; k++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = ra;
      for (int j = 0; j < 16; j++) begin
        if ($urandom_range(0, 3) == 0) rb[j*8 +: 8] = 8'($urandom);
        if ($urandom_range(0, 5) == 0) ra[j*8 +: 8] = 8'h00;
      end
      if (k % 3 == 0) rb = ~ra;
      drive("R4 R5 R6 random", ra, rb, 2'($urandom_range(0, 3)),
            1'($urandom), 1'($urandom));
    end
    repeat (3) @(negedge clk);
    check("R1 queue drained", 128'(q_res.size()), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule